// File: doc/BRIEF.md
# Integer Instruction Decode and Execute Stage

This block takes one 32-bit instruction word together with the two register values already read for its first and second source fields. It decodes the word and computes an integer result. One clock edge later it presents the destination register index, a write strobe, the 32-bit result and two exception flags: arithmetic overflow and illegal instruction. It handles a small integer subset of a classic three-format RISC encoding. The R-format operations are add and subu. The I-format operations are addi, addiu, slti, sltiu, ori and lui. The register file, memory, control transfer, shifts and multiply/divide are handled elsewhere.

The rules for immediate extension and trapping depend on the opcode. The "unsigned" immediate forms still sign-extend their 16-bit field. The "u" suffix only removes the overflow trap. sltiu sign-extends first and then compares without sign. ori is the only form that zero-extends. A pipeline places the block between register read and write-back. A word is offered by raising `in_valid`, and the outputs appear one cycle later qualified by `out_valid`.

Top module: `rdx_decode_exec`

## Requirements
- R1: The opcode is bits 31:26 and funct is bits 5:0. An R-format operation (opcode 0) reports the rd field, bits 15:11, as destination. An I-format operation reports the rt field, bits 20:16, as destination. Bits 25:21 name the first source.
- R2: Opcode 0 with funct 32 (add) gives opa + opb. If the signed sum overflows, out_ovf is 1, out_wen is 0, and out_result still shows the wrapped 32-bit sum.
- R3: Opcode 0 with funct 35 (subu) gives opa − opb modulo 2^32, and out_ovf is never raised.
- R4: Opcode 8 (addi) gives opa plus the sign-extended 16-bit immediate (bits 15:0). Signed overflow is trapped exactly as in R2.
- R5: Opcode 9 (addiu) gives opa plus the sign-extended immediate, and out_ovf is never raised.
- R6: Opcode 10 (slti) gives 1 when opa is less than the sign-extended immediate as signed numbers, else 0.
- R7: Opcode 11 (sltiu) sign-extends the immediate and then gives 1 when opa is less than it as unsigned numbers, else 0.
- R8: Opcode 13 (ori) gives opa OR the zero-extended immediate.
- R9: Opcode 15 (lui) places the immediate in result bits 31:16 and zeros in bits 15:0, independent of opa.
- R10: For a legal operation whose destination index is 0, out_wen is 0, while out_result and out_ovf are reported as usual.
- R11: These cases are illegal: any other opcode, opcode 0 with any other funct, opcode 0 with a nonzero shamt field (bits 10:6), and lui with a nonzero rs field. An illegal word raises out_illegal with out_wen 0, out_ovf 0, out_result 0 and out_dest 0.
- R12: The outputs for a word accepted with in_valid high appear after exactly one rising edge, with out_valid high. When out_valid is low, out_wen, out_ovf and out_illegal are all 0.
- R13: A synchronous reset clears out_valid, out_wen, out_ovf and out_illegal at the next rising edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Instruction word and operands are present this cycle |
| instr | input | 32 | Instruction word |
| opa | input | 32 | Register value read for the rs field |
| opb | input | 32 | Register value read for the rt field |
| out_valid | output | 1 | Registered outputs belong to an accepted word |
| out_dest | output | 5 | Destination register index |
| out_wen | output | 1 | Register write strobe |
| out_result | output | 32 | Computed result |
| out_ovf | output | 1 | Signed overflow trap on add or addi |
| out_illegal | output | 1 | Unsupported or malformed instruction word |

## Verification
The checker watches these properties on every cycle: the one-cycle valid timing, silent flags while invalid, the reset clear, and the write strobe's dependence on destination, overflow and illegality. It also checks that subu and addiu never trap, that set-less-than yields only 0 or 1, the lui placement, the rd destination of add, and the illegal flag for a lui with a nonzero rs field. The arithmetic itself can only be shown by the bench's scenarios: the wrapped sums at both overflow edges, the signed versus unsigned compares of a sign-extended immediate, the zero extension of ori, the shamt and funct rejections, and reset in the middle of a stream.

// File: rtl/rdx_pkg.sv
package rdx_pkg;

   // Fixed encoding geometry of the instruction word
   localparam int OPC_W   = 6;
   localparam int REG_AW  = 5;
   localparam int SHAMT_W = 5;
   localparam int FUNCT_W = 6;
   localparam int IMM_W   = 16;
   localparam int INSTR_W = OPC_W + 3 * REG_AW + SHAMT_W + FUNCT_W;

   // Field positions, derived from the most significant end downwards
   localparam int OPC_LSB   = INSTR_W - OPC_W;
   localparam int RS_LSB    = OPC_LSB - REG_AW;
   localparam int RT_LSB    = RS_LSB - REG_AW;
   localparam int RD_LSB    = RT_LSB - REG_AW;
   localparam int SHAMT_LSB = RD_LSB - SHAMT_W;
   localparam int FUNCT_LSB = 0;
   localparam int IMM_LSB   = 0;

   // Opcode and function codes
   localparam logic [OPC_W-1:0]   OPC_RTYPE = 6'd0;
   localparam logic [OPC_W-1:0]   OPC_ADDI  = 6'd8;
   localparam logic [OPC_W-1:0]   OPC_ADDIU = 6'd9;
   localparam logic [OPC_W-1:0]   OPC_SLTI  = 6'd10;
   localparam logic [OPC_W-1:0]   OPC_SLTIU = 6'd11;
   localparam logic [OPC_W-1:0]   OPC_ORI   = 6'd13;
   localparam logic [OPC_W-1:0]   OPC_LUI   = 6'd15;
   localparam logic [FUNCT_W-1:0] FN_ADD    = 6'd32;
   localparam logic [FUNCT_W-1:0] FN_SUBU   = 6'd35;

   typedef enum logic [2:0] {
      ALU_ADD,
      ALU_SUB,
      ALU_SLT,
      ALU_SLTU,
      ALU_OR,
      ALU_PASS_B
   } alu_op_e;

   typedef enum logic [1:0] {
      OPND_REG,
      OPND_SEXT,
      OPND_ZEXT,
      OPND_HIGH
   } opnd_mode_e;

   typedef struct packed {
      alu_op_e            op;
      opnd_mode_e         opnd_mode;
      logic               trap_en;
      logic               illegal;
      logic [REG_AW-1:0]  dest;
   } dec_t;

endpackage

// File: rtl/rdx_decode.sv
module rdx_decode
   import rdx_pkg::*;
(
   input  logic [OPC_W-1:0]   opc,
   input  logic [REG_AW-1:0]  rs_idx,
   input  logic [REG_AW-1:0]  rt_idx,
   input  logic [REG_AW-1:0]  rd_idx,
   input  logic [SHAMT_W-1:0] shamt,
   input  logic [FUNCT_W-1:0] funct,
   output dec_t               dec
);

   logic shamt_zero;
   assign shamt_zero = (shamt == '0);

   always_comb begin
      // Default: illegal word, no trap, destination 0
      dec.op        = ALU_OR;
      dec.opnd_mode = OPND_ZEXT;
      dec.trap_en   = 1'b0;
      dec.illegal   = 1'b1;
      dec.dest      = '0;

      case (opc)
         OPC_RTYPE: begin
            if (shamt_zero && funct == FN_ADD) begin
               dec.op        = ALU_ADD;
               dec.opnd_mode = OPND_REG;
               dec.trap_en   = 1'b1;
               dec.illegal   = 1'b0;
               dec.dest      = rd_idx;
            end else if (shamt_zero && funct == FN_SUBU) begin
               dec.op        = ALU_SUB;
               dec.opnd_mode = OPND_REG;
               dec.illegal   = 1'b0;
               dec.dest      = rd_idx;
            end
         end
         OPC_ADDI: begin
            dec.op        = ALU_ADD;
            dec.opnd_mode = OPND_SEXT;
            dec.trap_en   = 1'b1;
            dec.illegal   = 1'b0;
            dec.dest      = rt_idx;
         end
         OPC_ADDIU: begin
            dec.op        = ALU_ADD;
            dec.opnd_mode = OPND_SEXT;
            dec.illegal   = 1'b0;
            dec.dest      = rt_idx;
         end
         OPC_SLTI: begin
            dec.op        = ALU_SLT;
            dec.opnd_mode = OPND_SEXT;
            dec.illegal   = 1'b0;
            dec.dest      = rt_idx;
         end
         OPC_SLTIU: begin
            dec.op        = ALU_SLTU;
            dec.opnd_mode = OPND_SEXT;
            dec.illegal   = 1'b0;
            dec.dest      = rt_idx;
         end
         OPC_ORI: begin
            dec.op        = ALU_OR;
            dec.opnd_mode = OPND_ZEXT;
            dec.illegal   = 1'b0;
            dec.dest      = rt_idx;
         end
         OPC_LUI: begin
            if (rs_idx == '0) begin
               dec.op        = ALU_PASS_B;
               dec.opnd_mode = OPND_HIGH;
               dec.illegal   = 1'b0;
               dec.dest      = rt_idx;
            end
         end
         default: begin
            dec.illegal = 1'b1;
         end
      endcase
   end

endmodule

// File: rtl/rdx_operand.sv
module rdx_operand
   import rdx_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  opnd_mode_e         mode,
   input  logic [IMM_W-1:0]   imm,
   input  logic [DATA_W-1:0]  rt_val,
   output logic [DATA_W-1:0]  opnd
);

   localparam int FILL_W = DATA_W - IMM_W;

   always_comb begin
      case (mode)
         OPND_REG:  opnd = rt_val;
         OPND_SEXT: opnd = {{FILL_W{imm[IMM_W-1]}}, imm};
         OPND_ZEXT: opnd = {{FILL_W{1'b0}}, imm};
         default:   opnd = {imm, {FILL_W{1'b0}}};
      endcase
   end

endmodule

// File: rtl/rdx_alu.sv
module rdx_alu
   import rdx_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int CMP_STYLE = 0
) (
   input  alu_op_e            op,
   input  logic               trap_en,
   input  logic [DATA_W-1:0]  a,
   input  logic [DATA_W-1:0]  b,
   output logic [DATA_W-1:0]  result,
   output logic               ovf
);

   localparam int MSB = DATA_W - 1;

   logic              do_sub;
   logic [DATA_W-1:0] b_eff;
   logic [DATA_W:0]   ext;
   logic [DATA_W-1:0] sum;
   logic              add_ovf;
   logic              lt_s;
   logic              lt_u;

   always_comb begin
      do_sub = (op == ALU_SUB) || (op == ALU_SLT) || (op == ALU_SLTU);
      b_eff  = do_sub ? ~b : b;
   end

   // One shared carry chain serves add, subtract and both compares
   assign ext     = {1'b0, a} + {1'b0, b_eff} + {{DATA_W{1'b0}}, do_sub};
   assign sum     = ext[MSB:0];
   assign add_ovf = (a[MSB] == b[MSB]) && (sum[MSB] != a[MSB]);

   generate
      if (CMP_STYLE == 0) begin : g_cmp_shared
         // Compare derived from the subtractor: carry out and sign
         assign lt_s = (a[MSB] ^ b[MSB]) ? a[MSB] : sum[MSB];
         assign lt_u = ~ext[DATA_W];
      end else begin : g_cmp_direct
         // Separate magnitude comparators, shallower but larger
         assign lt_s = $signed(a) < $signed(b);
         assign lt_u = a < b;
      end
   endgenerate

   always_comb begin
      case (op)
         ALU_ADD,
         ALU_SUB:  result = sum;
         ALU_SLT:  result = {{MSB{1'b0}}, lt_s};
         ALU_SLTU: result = {{MSB{1'b0}}, lt_u};
         ALU_OR:   result = a | b;
         default:  result = b;
      endcase
      ovf = trap_en && (op == ALU_ADD) && add_ovf;
   end

endmodule

// File: rtl/rdx_outreg.sv
module rdx_outreg
   import rdx_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               in_valid,
   input  logic [REG_AW-1:0]  dest_d,
   input  logic               wen_d,
   input  logic [DATA_W-1:0]  result_d,
   input  logic               ovf_d,
   input  logic               illegal_d,
   output logic               valid_q,
   output logic [REG_AW-1:0]  dest_q,
   output logic               wen_q,
   output logic [DATA_W-1:0]  result_q,
   output logic               ovf_q,
   output logic               illegal_q
);

   // Control bits: reset, and forced low for an empty slot
   always_ff @(posedge clk) begin
      if (rst) begin
         valid_q   <= 1'b0;
         wen_q     <= 1'b0;
         ovf_q     <= 1'b0;
         illegal_q <= 1'b0;
      end else begin
         valid_q   <= in_valid;
         wen_q     <= in_valid & wen_d;
         ovf_q     <= in_valid & ovf_d;
         illegal_q <= in_valid & illegal_d;
      end
   end

   // Payload: loaded only for an accepted word, never reset
   always_ff @(posedge clk) begin
      if (in_valid) begin
         dest_q   <= dest_d;
         result_q <= result_d;
      end
   end

endmodule

// File: rtl/rdx_decode_exec.sv
module rdx_decode_exec
   import rdx_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int CMP_STYLE = 0
) (
   input  logic                clk,
   input  logic                rst,
   input  logic                in_valid,
   input  logic [INSTR_W-1:0]  instr,
   input  logic [DATA_W-1:0]   opa,
   input  logic [DATA_W-1:0]   opb,
   output logic                out_valid,
   output logic [REG_AW-1:0]   out_dest,
   output logic                out_wen,
   output logic [DATA_W-1:0]   out_result,
   output logic                out_ovf,
   output logic                out_illegal
);

   // Elaboration-time parameter checks
   generate
      if (DATA_W < 2 * IMM_W) begin : g_bad_data_w
         $error("rdx_decode_exec: DATA_W must hold two immediates");
      end
      if (CMP_STYLE != 0 && CMP_STYLE != 1) begin : g_bad_cmp_style
         $error("rdx_decode_exec: CMP_STYLE must be 0 or 1");
      end
      if (INSTR_W != OPC_W + 2 * REG_AW + IMM_W) begin : g_bad_geometry
         $error("rdx_decode_exec: I-format and R-format widths disagree");
      end
   endgenerate

   dec_t              dec;
   logic [DATA_W-1:0] opnd_b;
   logic [DATA_W-1:0] alu_res;
   logic              alu_ovf;
   logic [DATA_W-1:0] res_d;
   logic              wen_d;

   rdx_decode u_decode (
      .opc    (instr[OPC_LSB +: OPC_W]),
      .rs_idx (instr[RS_LSB +: REG_AW]),
      .rt_idx (instr[RT_LSB +: REG_AW]),
      .rd_idx (instr[RD_LSB +: REG_AW]),
      .shamt  (instr[SHAMT_LSB +: SHAMT_W]),
      .funct  (instr[FUNCT_LSB +: FUNCT_W]),
      .dec    (dec)
   );

   rdx_operand #(
      .DATA_W (DATA_W)
   ) u_operand (
      .mode   (dec.opnd_mode),
      .imm    (instr[IMM_LSB +: IMM_W]),
      .rt_val (opb),
      .opnd   (opnd_b)
   );

   rdx_alu #(
      .DATA_W    (DATA_W),
      .CMP_STYLE (CMP_STYLE)
   ) u_alu (
      .op      (dec.op),
      .trap_en (dec.trap_en),
      .a       (opa),
      .b       (opnd_b),
      .result  (alu_res),
      .ovf     (alu_ovf)
   );

   assign res_d = dec.illegal ? '0 : alu_res;
   assign wen_d = !dec.illegal && !alu_ovf && (dec.dest != '0);

   rdx_outreg #(
      .DATA_W (DATA_W)
   ) u_outreg (
      .clk       (clk),
      .rst       (rst),
      .in_valid  (in_valid),
      .dest_d    (dec.dest),
      .wen_d     (wen_d),
      .result_d  (res_d),
      .ovf_d     (alu_ovf),
      .illegal_d (dec.illegal),
      .valid_q   (out_valid),
      .dest_q    (out_dest),
      .wen_q     (out_wen),
      .result_q  (out_result),
      .ovf_q     (out_ovf),
      .illegal_q (out_illegal)
   );

endmodule

// File: rtl/rdx_checker.sv
module rdx_checker #(
   parameter int DATA_W = 32
) (
   input logic              clk,
   input logic              rst,
   input logic              in_valid,
   input logic [31:0]       instr,
   input logic              out_valid,
   input logic [4:0]        out_dest,
   input logic              out_wen,
   input logic [DATA_W-1:0] out_result,
   input logic              out_ovf,
   input logic              out_illegal
);

   logic primed = 1'b0;
   always_ff @(posedge clk) primed <= 1'b1;

   assert_valid_follows_R12: assert property (@(posedge clk) disable iff (rst)
      !$past(rst) |-> (out_valid == $past(in_valid)));

   assert_quiet_when_idle_R12: assert property (@(posedge clk) disable iff (rst)
      !out_valid |-> (!out_wen && !out_ovf && !out_illegal));

   assert_reset_clears_R13: assert property (@(posedge clk)
      (primed && $past(rst)) |-> (!out_valid && !out_wen && !out_ovf && !out_illegal));

   assert_wen_rules_R10: assert property (@(posedge clk) disable iff (rst)
      out_wen |-> (out_dest != 5'd0 && !out_ovf && !out_illegal));

   assert_illegal_no_trap_R11: assert property (@(posedge clk) disable iff (rst)
      out_illegal |-> (!out_ovf && out_result == '0 && out_dest == 5'd0));

   assert_lui_rs_illegal_R11: assert property (@(posedge clk) disable iff (rst)
      (in_valid && instr[31:26] == 6'd15 && instr[25:21] != 5'd0) |=> out_illegal);

   assert_subu_no_trap_R3: assert property (@(posedge clk) disable iff (rst)
      (in_valid && instr[31:26] == 6'd0 && instr[5:0] == 6'd35) |=> !out_ovf);

   assert_addiu_no_trap_R5: assert property (@(posedge clk) disable iff (rst)
      (in_valid && instr[31:26] == 6'd9) |=> !out_ovf);

   assert_slt_bool_R6: assert property (@(posedge clk) disable iff (rst)
      (in_valid && (instr[31:26] == 6'd10 || instr[31:26] == 6'd11))
      |=> (out_result[DATA_W-1:1] == '0));

   assert_lui_place_R9: assert property (@(posedge clk) disable iff (rst)
      (in_valid && instr[31:26] == 6'd15 && instr[25:21] == 5'd0)
      |=> (out_result[DATA_W-1 -: 16] == $past(instr[15:0])
           && out_result[DATA_W-17:0] == '0
           && out_dest == $past(instr[20:16])));

   assert_rformat_dest_R1: assert property (@(posedge clk) disable iff (rst)
      (in_valid && instr[31:26] == 6'd0 && instr[5:0] == 6'd32 && instr[10:6] == 5'd0)
      |=> (out_dest == $past(instr[15:11]) && !out_illegal));

endmodule

bind rdx_decode_exec rdx_checker #(.DATA_W(DATA_W)) u_rdx_checker (.*);

// File: tb/rdx_decode_exec_bench.sv
`timescale 1ns/1ps
module rdx_decode_exec_bench;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        in_valid = 1'b0;
   logic [31:0] instr = '0;
   logic [31:0] opa = '0;
   logic [31:0] opb = '0;
   logic        out_valid;
   logic [4:0]  out_dest;
   logic        out_wen;
   logic [31:0] out_result;
   logic        out_ovf;
   logic        out_illegal;

   int n_cmp  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   rdx_decode_exec u_rdx_decode_exec (
      .clk         (clk),
      .rst         (rst),
      .in_valid    (in_valid),
      .instr       (instr),
      .opa         (opa),
      .opb         (opb),
      .out_valid   (out_valid),
      .out_dest    (out_dest),
      .out_wen     (out_wen),
      .out_result  (out_result),
      .out_ovf     (out_ovf),
      .out_illegal (out_illegal)
   );

   typedef struct {
      bit        v;
      bit        wen;
      bit        ovf;
      bit        ill;
      bit [4:0]  dest;
      bit [31:0] res;
      string     tag;
   } exp_t;

   exp_t pend[$];

   function automatic bit [31:0] r_word(bit [4:0] rs, bit [4:0] rt, bit [4:0] rd,
                                        bit [4:0] sh, bit [5:0] fn);
      return {6'd0, rs, rt, rd, sh, fn};
   endfunction

   function automatic bit [31:0] i_word(bit [5:0] op, bit [4:0] rs, bit [4:0] rt,
                                        bit [15:0] imm);
      return {op, rs, rt, imm};
   endfunction

   // Behavioural reference, written from the requirements
   function automatic exp_t model(bit r, bit v, bit [31:0] ins, bit [31:0] a, bit [31:0] b);
      exp_t      e;
      longint    s;
      bit [31:0] simm;
      bit [31:0] zimm;
      bit [5:0]  opc;
      bit [5:0]  fn;
      e.v = 0; e.wen = 0; e.ovf = 0; e.ill = 0; e.dest = 0; e.res = 0; e.tag = "R12";
      if (r) begin
         e.tag = "R13";
         return e;
      end
      if (!v) return e;
      e.v  = 1;
      opc  = ins[31:26];
      fn   = ins[5:0];
      simm = {{16{ins[15]}}, ins[15:0]};
      zimm = {16'h0000, ins[15:0]};
      case (opc)
         6'd0: begin
            if (ins[10:6] != 0 || !(fn == 6'd32 || fn == 6'd35)) e.ill = 1;
            else if (fn == 6'd32) begin
               s = longint'($signed(a)) + longint'($signed(b));
               e.res = s[31:0];
               e.ovf = (s > 64'sd2147483647) || (s < -64'sd2147483648);
               e.dest = ins[15:11]; e.tag = "R1+R2";
            end else begin
               e.res = a - b; e.dest = ins[15:11]; e.tag = "R3";
            end
         end
         6'd8: begin
            s = longint'($signed(a)) + longint'($signed(simm));
            e.res = s[31:0];
            e.ovf = (s > 64'sd2147483647) || (s < -64'sd2147483648);
            e.dest = ins[20:16]; e.tag = "R1+R4";
         end
         6'd9:  begin e.res = a + simm; e.dest = ins[20:16]; e.tag = "R5"; end
         6'd10: begin e.res = ($signed(a) < $signed(simm)) ? 32'd1 : 32'd0;
                      e.dest = ins[20:16]; e.tag = "R6"; end
         6'd11: begin e.res = (a < simm) ? 32'd1 : 32'd0;
                      e.dest = ins[20:16]; e.tag = "R7"; end
         6'd13: begin e.res = a | zimm; e.dest = ins[20:16]; e.tag = "R8"; end
         6'd15: begin
            if (ins[25:21] != 0) e.ill = 1;
            else begin e.res = {ins[15:0], 16'h0000}; e.dest = ins[20:16]; e.tag = "R9"; end
         end
         default: e.ill = 1;
      endcase
      if (e.ill) begin
         e.tag = "R11"; e.res = 0; e.dest = 0; e.ovf = 0;
      end else if (e.dest == 0) begin
         e.tag = {e.tag, " R10"};
      end
      e.wen = !e.ill && !e.ovf && (e.dest != 0);
      return e;
   endfunction

   task automatic check(exp_t e);
      bit bad;
      n_cmp++;
      bad = (out_valid !== e.v) || (out_wen !== e.wen) || (out_ovf !== e.ovf)
            || (out_illegal !== e.ill);
      if (e.v) bad = bad || (out_dest !== e.dest) || (out_result !== e.res);
      if (bad) begin
         n_fail++;
         $display("FAIL %s: got v=%0b wen=%0b ovf=%0b ill=%0b dest=%0d res=%h, expected v=%0b wen=%0b ovf=%0b ill=%0b dest=%0d res=%h",
                  e.tag, out_valid, out_wen, out_ovf, out_illegal, out_dest, out_result,
                  e.v, e.wen, e.ovf, e.ill, e.dest, e.res);
      end
   endtask

   // Compare last cycle's expectation, then drive the next cycle
   task automatic step(bit r, bit v, bit [31:0] ins, bit [31:0] a, bit [31:0] b);
      @(negedge clk);
      if (pend.size() > 0) check(pend.pop_front());
      rst      = r;
      in_valid = v;
      instr    = ins;
      opa      = a;
      opb      = b;
      pend.push_back(model(r, v, ins, a, b));
   endtask

   task automatic summary();
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
   endtask

   initial begin
      bit [5:0] menu [10] = '{6'd0, 6'd0, 6'd8, 6'd9, 6'd10, 6'd11, 6'd13, 6'd15, 6'd2, 6'd35};
      // R13: reset state
      step(1, 0, 32'h0, 32'h0, 32'h0);
      step(1, 1, 32'h012A4020, 32'd5, 32'd7);
      step(1, 0, 32'h0, 32'h0, 32'h0);
      // R1, R2: add with rd=8 from the canonical word
      step(0, 1, 32'h012A4020, 32'd5, 32'd7);
      // R1, R4: addi rt=21, immediate -50
      step(0, 1, 32'h22D5FFCE, 32'd100, 32'hDEAD_BEEF);
      // R2: positive and negative overflow, wrapped sum kept
      step(0, 1, r_word(5'd1, 5'd2, 5'd3, 5'd0, 6'd32), 32'h7FFF_FFFF, 32'h1);
      step(0, 1, r_word(5'd1, 5'd2, 5'd3, 5'd0, 6'd32), 32'h8000_0000, 32'hFFFF_FFFF);
      step(0, 1, r_word(5'd1, 5'd2, 5'd3, 5'd0, 6'd32), 32'h8000_0000, 32'h7FFF_FFFF);
      // R10: add to register 0
      step(0, 1, r_word(5'd1, 5'd2, 5'd0, 5'd0, 6'd32), 32'd1, 32'd2);
      step(0, 1, r_word(5'd1, 5'd2, 5'd0, 5'd0, 6'd32), 32'h7FFF_FFFF, 32'h7FFF_FFFF);
      // R3: subu wraps without trapping
      step(0, 1, r_word(5'd4, 5'd5, 5'd6, 5'd0, 6'd35), 32'h8000_0000, 32'h1);
      step(0, 1, r_word(5'd4, 5'd5, 5'd6, 5'd0, 6'd35), 32'h3, 32'h5);
      // R4 / R5: same overflow operands, trapped only by addi
      step(0, 1, i_word(6'd8, 5'd1, 5'd9, 16'h0001), 32'h7FFF_FFFF, 32'h0);
      step(0, 1, i_word(6'd8, 5'd1, 5'd9, 16'hFFFF), 32'h8000_0000, 32'h0);
      step(0, 1, i_word(6'd9, 5'd1, 5'd9, 16'h0001), 32'h7FFF_FFFF, 32'h0);
      step(0, 1, i_word(6'd9, 5'd1, 5'd9, 16'h8000), 32'h0001_0000, 32'h0);
      // R6: signed compare with sign-extended immediate
      step(0, 1, i_word(6'd10, 5'd1, 5'd7, 16'h0001), 32'hFFFF_FFFF, 32'h0);
      step(0, 1, i_word(6'd10, 5'd1, 5'd7, 16'hFFFD), 32'd5, 32'h0);
      // R7: unsigned compare after sign extension
      step(0, 1, i_word(6'd11, 5'd1, 5'd7, 16'hFFFF), 32'd5, 32'h0);
      step(0, 1, i_word(6'd11, 5'd1, 5'd7, 16'hFFFF), 32'hFFFF_FFFF, 32'h0);
      step(0, 1, i_word(6'd11, 5'd1, 5'd7, 16'h8000), 32'h7FFF_FFFF, 32'h0);
      // R8: zero-extended OR
      step(0, 1, i_word(6'd13, 5'd1, 5'd8, 16'h8001), 32'h1234_0000, 32'h0);
      // R9: lui ignores opa; then the matching ori
      step(0, 1, i_word(6'd15, 5'd0, 5'd8, 16'hABAB), 32'hFFFF_FFFF, 32'h0);
      step(0, 1, i_word(6'd13, 5'd8, 5'd8, 16'hCDCD), 32'hABAB_0000, 32'h0);
      // R11: unsupported opcode, funct, nonzero shamt, lui with rs set
      step(0, 1, 32'h0800_0010, 32'd1, 32'd2);
      step(0, 1, r_word(5'd1, 5'd2, 5'd3, 5'd0, 6'd33), 32'h7FFF_FFFF, 32'h1);
      step(0, 1, r_word(5'd1, 5'd2, 5'd3, 5'd4, 6'd32), 32'd1, 32'd2);
      step(0, 1, i_word(6'd15, 5'd3, 5'd8, 16'h1234), 32'd0, 32'd0);
      step(0, 1, i_word(6'd35, 5'd0, 5'd0, 16'h0000), 32'd0, 32'd0);
      // R12: idle slot with an overflowing word present
      step(0, 0, r_word(5'd1, 5'd2, 5'd3, 5'd0, 6'd32), 32'h7FFF_FFFF, 32'h1);
      step(0, 0, 32'hFFFF_FFFF, 32'h0, 32'h0);
      // R13: reset in the middle of a stream
      step(0, 1, r_word(5'd1, 5'd2, 5'd3, 5'd0, 6'd32), 32'h7FFF_FFFF, 32'h1);
      step(1, 1, 32'h0000_0000, 32'h0, 32'h0);
      step(0, 1, i_word(6'd13, 5'd1, 5'd2, 16'h00FF), 32'h0F00, 32'h0);
      // Mixed stream over the whole menu, with gaps
      for (int i = 0; i < 400; i++) begin
         bit [5:0]  op;
         bit [31:0] w;
         bit [31:0] a;
         bit [31:0] b;
         op = menu[$urandom_range(0, 9)];
         w  = $urandom();
         if (op == 6'd0) begin
            w[31:26] = 6'd0;
            w[10:6]  = ($urandom_range(0, 7) == 0) ? w[10:6] : 5'd0;
            w[5:0]   = ($urandom_range(0, 1) == 0) ? 6'd32 : 6'd35;
         end else begin
            w[31:26] = op;
            if (op == 6'd15 && $urandom_range(0, 3) != 0) w[25:21] = 5'd0;
         end
         a = ($urandom_range(0, 3) == 0) ? {$urandom_range(0, 1) == 1, 31'h7FFF_FFFF} : $urandom();
         b = ($urandom_range(0, 3) == 0) ? {$urandom_range(0, 1) == 1, 31'h0} : $urandom();
         step(0, $urandom_range(0, 4) != 0, w, a, b);
      end
      step(0, 0, 32'h0, 32'h0, 32'h0);
      step(0, 0, 32'h0, 32'h0, 32'h0);
      done = 1'b1;
      summary();
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_fail++;
         $display("FAIL R12: watchdog expired, got no end of stream, expected completion");
         summary();
         $finish;
      end
   end

endmodule